// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a word-addressed scratchpad split into sixteen independent banks, each able to read or write one 32-bit word per clock. A request carries sixteen lanes at once. Each lane has its own valid flag, word address, write enable and write data. The block maps every lane to a bank from the low bits of its address. When two or more lanes land in the same bank, it serves them in sequential passes. When every lane lands in a different bank, the whole request finishes in one pass.

A requester raises `req_valid` while `req_ready` is high, and the lane fields are captured on that edge. `req_ready` stays low while the passes run. When the last pass completes, `done` pulses for one cycle. At that point the read data for all lanes and the number of passes used (`degree`) are both available together. Only one request is outstanding at a time.

Top module: `bank_scratch`

## Requirements
- R1: A lane's bank is its word address modulo 16 (address bits [3:0]); its row inside that bank is the address divided by 16 (bits [9:4]), so every one of the 1024 words is distinct and consecutive words sit in consecutive banks.
- R2: A request whose valid lanes all map to different banks (stride 1, or any one-to-one bank permutation) takes one pass: `done` is high in the cycle after the accepting edge.
- R3: The number of passes equals the largest count of valid lanes mapped to any one bank: stride 2 takes 2, stride 8 takes 8, and sixteen lanes down one column of a 16x16 word array take 16. `done` rises exactly that many cycles after the accepting edge.
- R4: Lanes with the valid bit clear are skipped. They do not add to any bank's load, do not write memory even with write enable set, and return zero read data.
- R5: In each pass, each bank serves its lowest-numbered lane that is still pending. So within one request, lanes touching the same word take effect in ascending lane order: a read sees writes from lower lanes, and the highest writing lane's data remains.
- R6: With `done`, `rdata` holds, for each valid read lane, the word read in that lane's pass. Write lanes and invalid lanes return zero. `rdata` is held until the next request is accepted.
- R7: `req_ready` drops on the edge that accepts a request with at least one valid lane, and rises again in the same cycle as `done`. A request with no valid lanes completes at once: `done` is high in the cycle after acceptance, `degree` is 0, and `req_ready` stays high.
- R8: `degree` shows the number of passes used by the last completed request, valid from its `done` cycle and held until the next completion.
- R9: After reset, `req_ready` is 1, and `done`, `degree` and `rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| lane_valid | input | 16 | Per-lane participation flag |
| lane_addr | input | 160 | Per-lane word address, lane n in bits [10n+9:10n] |
| lane_we | input | 16 | Per-lane write enable |
| lane_wdata | input | 512 | Per-lane write word, lane n in bits [32n+31:32n] |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 512 | Per-lane read word, same packing as lane_wdata |
| degree | output | 5 | Passes used by the last request |

## Verification
Several address patterns are used, and each one separates a different wrong design. Unit stride and a scrambled bank permutation show that distinct banks really run in parallel. Strides of 2, 8 and 16 produce loads of 2, 8 and 16 and pin down the pass count exactly. Requests with the same address across lanes check that lower lanes go first. Partly valid and fully invalid requests show that skipped lanes neither add load nor write memory. Random short-range addresses with mixed writes compare every lane's data and the pass count against a model that applies the lanes in ascending order.

// File: rtl/scratch_pkg.sv
// Shared types for the banked scratchpad.
// Assumes: nothing beyond the standard language.
package scratch_pkg;
    typedef enum logic {
        SP_IDLE  = 1'b0,
        SP_SERVE = 1'b1
    } sp_state_e;
endpackage

// File: rtl/scratch_bank_ram.sv
// One bank of the scratchpad: a word array with a synchronous write port
// and an asynchronous read port.
// Assumes: at most one access per cycle, as chosen by the bank arbiter.
module scratch_bank_ram #(
    parameter int DATA_W = 32,
    parameter int ROW_W  = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the word on a write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[row] <= wr_data;
    end

    assign rd_data = mem[row];
endmodule

// File: rtl/scratch_bank_arb.sv
// Per-bank picker: among pending lanes whose bank index equals BANK_ID,
// grants the lowest-numbered one.
// Assumes: lane bank indices are packed BANK_W bits per lane.
module scratch_bank_arb #(
    parameter int NUM_LANES = 16,
    parameter int BANK_W    = 4,
    parameter int BANK_ID   = 0,
    localparam int LANE_W   = $clog2(NUM_LANES)
) (
    input  logic [NUM_LANES-1:0]        pending,
    input  logic [NUM_LANES*BANK_W-1:0] lane_bank,
    output logic [NUM_LANES-1:0]        grant,
    output logic                        hit,
    output logic [LANE_W-1:0]           sel
);
    // Descending scan so that the lowest matching lane is the last writer.
    always_comb begin
        hit   = 1'b0;
        sel   = '0;
        grant = '0;
        for (int l = NUM_LANES - 1; l >= 0; l--) begin
            if (pending[l] && lane_bank[l*BANK_W +: BANK_W] == BANK_W'(BANK_ID)) begin
                hit = 1'b1;
                sel = LANE_W'(l);
            end
        end
        if (hit) grant[sel] = 1'b1;
    end
endmodule

// File: rtl/scratch_load_count.sv
// Counts valid lanes per bank and reports the heaviest bank's load,
// which is the number of passes the request will need.
// Assumes: NUM_BANKS is a power of two.
module scratch_load_count #(
    parameter int NUM_LANES = 16,
    parameter int NUM_BANKS = 16,
    parameter int BANK_W    = 4,
    parameter int CNT_W     = 5
) (
    input  logic [NUM_LANES-1:0]        valid,
    input  logic [NUM_LANES*BANK_W-1:0] lane_bank,
    output logic [CNT_W-1:0]            max_load
);
    logic [CNT_W-1:0] load [NUM_BANKS];

    // Tally each bank, then keep the maximum.
    always_comb begin
        max_load = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            load[b] = '0;
            for (int l = 0; l < NUM_LANES; l++) begin
                if (valid[l] && lane_bank[l*BANK_W +: BANK_W] == BANK_W'(b))
                    load[b] = load[b] + CNT_W'(1);
            end
            if (load[b] > max_load) max_load = load[b];
        end
    end
endmodule

// File: rtl/bank_scratch.sv
// Banked scratchpad top. Captures a multi-lane request, then in every
// serve cycle lets each bank handle its lowest pending lane, until no
// lane is pending. Then it pulses done, with read data and pass count.
// Assumes: one request in flight; NUM_BANKS is a power of two and
// ADDR_W > log2(NUM_BANKS).
module bank_scratch #(
    parameter int NUM_LANES = 16,
    parameter int NUM_BANKS = 16,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    localparam int CNT_W    = $clog2(NUM_LANES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [NUM_LANES-1:0]        lane_valid,
    input  logic [NUM_LANES*ADDR_W-1:0] lane_addr,
    input  logic [NUM_LANES-1:0]        lane_we,
    input  logic [NUM_LANES*DATA_W-1:0] lane_wdata,
    output logic                        done,
    output logic [NUM_LANES*DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]            degree
);
    import scratch_pkg::*;

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam int LANE_W = $clog2(NUM_LANES);

    sp_state_e                   state;
    logic [NUM_LANES-1:0]        pend;
    logic [NUM_LANES*ADDR_W-1:0] addr_q;
    logic [NUM_LANES-1:0]        we_q;
    logic [NUM_LANES*DATA_W-1:0] wdata_q;
    logic [NUM_LANES*DATA_W-1:0] rdata_q;
    logic                        done_q;
    logic [CNT_W-1:0]            degree_q;
    logic [CNT_W-1:0]            pass_cnt;
    logic [CNT_W-1:0]            planned_q;
    logic [CNT_W-1:0]            max_load;

    logic [NUM_LANES*BANK_W-1:0]    bank_in;
    logic [NUM_LANES*BANK_W-1:0]    bank_q;
    logic [NUM_LANES-1:0]           serve_mask;
    logic [NUM_LANES-1:0]           lane_grant;
    logic [NUM_BANKS*NUM_LANES-1:0] bank_grant_flat;
    logic [DATA_W-1:0]              bank_rd [NUM_BANKS];

    // Bank index of every lane, for incoming and held addresses.
    always_comb begin
        for (int l = 0; l < NUM_LANES; l++) begin
            bank_in[l*BANK_W +: BANK_W] = lane_addr[l*ADDR_W +: BANK_W];
            bank_q[l*BANK_W +: BANK_W]  = addr_q[l*ADDR_W +: BANK_W];
        end
    end

    assign serve_mask = (state == SP_SERVE) ? pend : '0;

    scratch_load_count #(
        .NUM_LANES (NUM_LANES),
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .CNT_W     (CNT_W)
    ) u_load (
        .valid     (lane_valid),
        .lane_bank (bank_in),
        .max_load  (max_load)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [NUM_LANES-1:0] grant_b;
        logic                 hit_b;
        logic [LANE_W-1:0]    sel_b;

        scratch_bank_arb #(
            .NUM_LANES (NUM_LANES),
            .BANK_W    (BANK_W),
            .BANK_ID   (b)
        ) u_arb (
            .pending   (serve_mask),
            .lane_bank (bank_q),
            .grant     (grant_b),
            .hit       (hit_b),
            .sel       (sel_b)
        );

        scratch_bank_ram #(
            .DATA_W (DATA_W),
            .ROW_W  (ROW_W)
        ) u_ram (
            .clk     (clk),
            .wr_en   (hit_b && we_q[sel_b]),
            .row     (addr_q[sel_b*ADDR_W + BANK_W +: ROW_W]),
            .wr_data (wdata_q[sel_b*DATA_W +: DATA_W]),
            .rd_data (bank_rd[b])
        );

        assign bank_grant_flat[b*NUM_LANES +: NUM_LANES] = grant_b;
    end

    // Merge the per-bank grants into one lane mask.
    always_comb begin
        lane_grant = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            lane_grant = lane_grant | bank_grant_flat[b*NUM_LANES +: NUM_LANES];
    end

    // Request capture, pass sequencing and result collection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SP_IDLE;
            pend      <= '0;
            addr_q    <= '0;
            we_q      <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            done_q    <= 1'b0;
            degree_q  <= '0;
            pass_cnt  <= '0;
            planned_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                SP_IDLE: begin
                    if (req_valid) begin
                        addr_q    <= lane_addr;
                        we_q      <= lane_we;
                        wdata_q   <= lane_wdata;
                        rdata_q   <= '0;
                        pass_cnt  <= '0;
                        planned_q <= max_load;
                        pend      <= lane_valid;
                        if (|lane_valid) begin
                            state <= SP_SERVE;
                        end else begin
                            done_q   <= 1'b1;
                            degree_q <= '0;
                        end
                    end
                end
                SP_SERVE: begin
                    pend     <= pend & ~lane_grant;
                    pass_cnt <= pass_cnt + CNT_W'(1);
                    for (int l = 0; l < NUM_LANES; l++) begin
                        if (lane_grant[l] && !we_q[l])
                            rdata_q[l*DATA_W +: DATA_W] <= bank_rd[bank_q[l*BANK_W +: BANK_W]];
                    end
                    if ((pend & ~lane_grant) == '0) begin
                        state    <= SP_IDLE;
                        done_q   <= 1'b1;
                        degree_q <= pass_cnt + CNT_W'(1);
                    end
                end
                default: state <= SP_IDLE;
            endcase
        end
    end

    assign req_ready = (state == SP_IDLE);
    assign done      = done_q;
    assign rdata     = rdata_q;
    assign degree    = degree_q;
endmodule

// File: rtl/scratch_chk.sv
// Protocol and sequencing checks for the banked scratchpad, bound to
// every instance of the top.
// Assumes: signals are sampled on the rising clock edge.
module scratch_chk #(
    parameter int NL    = 16,
    parameter int NB    = 16,
    parameter int CNT_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [NL-1:0]     lane_valid,
    input logic              done,
    input logic [CNT_W-1:0]  degree,
    input logic [CNT_W-1:0]  planned,
    input logic [NL-1:0]     pend,
    input logic [NL-1:0]     lane_grant,
    input logic [NB*NL-1:0]  bank_grant
);
    // R3
    degree_matches_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> degree == planned);

    // R5
    for (genvar b = 0; b < NB; b++) begin : g_one
        one_lane_per_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(bank_grant[b*NL +: NL]));
    end

    // R4
    grant_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_grant & ~pend) == '0);

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (|lane_valid)) |=> !req_ready);

    // R7
    done_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    // R3
    busy_makes_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> lane_grant != '0);
endmodule

bind bank_scratch scratch_chk #(
    .NL    (NUM_LANES),
    .NB    (NUM_BANKS),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .lane_valid (lane_valid),
    .done       (done),
    .degree     (degree),
    .planned    (planned_q),
    .pend       (pend),
    .lane_grant (lane_grant),
    .bank_grant (bank_grant_flat)
);

// File: tb/bank_scratch_test.sv
`timescale 1ns/1ps
module bank_scratch_test;
    localparam int NL = 16;
    localparam int NB = 16;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int CW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [NL-1:0]     lane_valid = '0;
    logic [NL*AW-1:0]  lane_addr = '0;
    logic [NL-1:0]     lane_we = '0;
    logic [NL*DW-1:0]  lane_wdata = '0;
    logic              done;
    logic [NL*DW-1:0]  rdata;
    logic [CW-1:0]     degree;

    logic [DW-1:0] model [1<<AW];
    logic [AW-1:0] la [NL];
    logic [DW-1:0] lw [NL];
    bit            lv [NL];
    bit            lwe [NL];

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bank_scratch uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .lane_valid(lane_valid), .lane_addr(lane_addr), .lane_we(lane_we),
        .lane_wdata(lane_wdata), .done(done), .rdata(rdata), .degree(degree)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_passes();
        int cnt [NB];
        int mx = 0;
        for (int b = 0; b < NB; b++) cnt[b] = 0;
        for (int l = 0; l < NL; l++)
            if (lv[l]) cnt[la[l] % NB]++;
        for (int b = 0; b < NB; b++) if (cnt[b] > mx) mx = cnt[b];
        return mx;
    endfunction

    function automatic void clear_lanes();
        for (int l = 0; l < NL; l++) begin
            lv[l] = 1'b0; lwe[l] = 1'b0; la[l] = '0; lw[l] = '0;
        end
    endfunction

    // Sends the staged lanes and checks latency, pass count, ready and data.
    task automatic run(input string rtag);
        logic [DW-1:0] expd [NL];
        int  passes;
        int  n;
        bit  busy_ok;
        bit  data_ok;
        int  bad;
        passes = exp_passes();
        for (int l = 0; l < NL; l++) begin
            expd[l] = '0;
            if (lv[l]) begin
                if (lwe[l]) model[la[l]] = lw[l];
                else        expd[l] = model[la[l]];
            end
        end
        @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            lane_valid[l]            = lv[l];
            lane_we[l]               = lwe[l];
            lane_addr[l*AW +: AW]    = la[l];
            lane_wdata[l*DW +: DW]   = lw[l];
        end
        chk(req_ready == 1'b1, "R7", "ready before request", DW'(req_ready), 1);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        busy_ok = 1'b1;
        while (!done && n < 40) begin
            if (req_ready) busy_ok = 1'b0;
            n++;
            @(negedge clk);
        end
        chk(n == passes, rtag, "cycles to done", DW'(n), DW'(passes));
        chk(degree == CW'(passes), "R8", "degree", DW'(degree), DW'(passes));
        chk(busy_ok, "R7", "ready low while busy", DW'(busy_ok), 1);
        data_ok = 1'b1;
        bad = 0;
        for (int l = NL - 1; l >= 0; l--)
            if (rdata[l*DW +: DW] !== expd[l]) begin data_ok = 1'b0; bad = l; end
        chk(data_ok, "R6", $sformatf("rdata lane %0d", bad), rdata[bad*DW +: DW], expd[bad]);
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(req_ready == 1'b1, "R9", "ready in reset", DW'(req_ready), 1);
        chk(done == 1'b0 && degree == '0 && rdata == '0, "R9", "outputs in reset",
            DW'(done) | DW'(degree), 0);
        rst_n = 1'b1;

        // Fill memory with unit-stride writes (R2).
        for (int r = 0; r < (1 << AW) / NL; r++) begin
            for (int l = 0; l < NL; l++) begin
                lv[l] = 1'b1; lwe[l] = 1'b1;
                la[l] = AW'(r * NL + l); lw[l] = $urandom;
            end
            run("R2");
        end

        // R1: bank permutation across different rows, each word distinct.
        for (int l = 0; l < NL; l++) begin
            lv[l] = 1'b1; lwe[l] = 1'b0; la[l] = AW'(((l * 5) % 16) + 16 * (l * 3 + 1));
        end
        run("R1");

        // R2: unit-stride read.
        for (int l = 0; l < NL; l++) begin lv[l] = 1'b1; lwe[l] = 1'b0; la[l] = AW'(32 + l); end
        run("R2");

        // R3: stride 2, stride 8, column of a 16x16 array.
        for (int l = 0; l < NL; l++) begin lv[l] = 1'b1; lwe[l] = 1'b0; la[l] = AW'(2 * l); end
        run("R3");
        for (int l = 0; l < NL; l++) la[l] = AW'(8 * l + 1);
        run("R3");
        for (int l = 0; l < NL; l++) la[l] = AW'(16 * l + 3);
        run("R3");

        // R4: only three valid lanes; invalid ones try to write.
        clear_lanes();
        for (int l = 0; l < NL; l++) begin la[l] = AW'(16 * l + 7); lwe[l] = 1'b1; lw[l] = 32'hDEAD0000 + l; end
        lv[0] = 1'b1; lv[5] = 1'b1; lv[9] = 1'b1; lwe[5] = 1'b0;
        run("R4");
        clear_lanes();
        for (int l = 0; l < NL; l++) begin lv[l] = 1'b1; la[l] = AW'(16 * l + 7); end
        run("R4");

        // R7: no valid lanes, even with writes requested.
        clear_lanes();
        for (int l = 0; l < NL; l++) begin lwe[l] = 1'b1; la[l] = AW'(l); lw[l] = 32'hFFFF_FFFF; end
        run("R7");
        clear_lanes();
        for (int l = 0; l < NL; l++) begin lv[l] = 1'b1; la[l] = AW'(l); end
        run("R4");

        // R5: same word, writes then read in lane order.
        clear_lanes();
        lv[2] = 1'b1; lwe[2] = 1'b1; la[2] = AW'(100); lw[2] = 32'h1111_2222;
        lv[4] = 1'b1; lwe[4] = 1'b1; la[4] = AW'(100); lw[4] = 32'h3333_4444;
        lv[7] = 1'b1; lwe[7] = 1'b0; la[7] = AW'(100);
        lv[1] = 1'b1; lwe[1] = 1'b0; la[1] = AW'(100);
        run("R5");
        clear_lanes();
        lv[10] = 1'b1; lwe[10] = 1'b1; la[10] = AW'(200); lw[10] = 32'hAAAA_0001;
        lv[12] = 1'b1; lwe[12] = 1'b1; la[12] = AW'(200); lw[12] = 32'hBBBB_0002;
        run("R5");
        clear_lanes();
        lv[0] = 1'b1; la[0] = AW'(200);
        run("R5");

        // Random mixes over a small window to force conflicts (R3).
        for (int t = 0; t < 60; t++) begin
            for (int l = 0; l < NL; l++) begin
                lv[l]  = ($urandom % 4) != 0;
                lwe[l] = ($urandom % 3) == 0;
                la[l]  = AW'(($urandom % 64) + 256);
                lw[l]  = $urandom;
            end
            run("R3");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule